// File: doc/BRIEF.md
# Serial Frame Bit Formatter

This block translates between a 32-bit buffer word and the shift-register image of a single serial frame. A transmit request takes a right-aligned data word and produces the image that a shifter sends out starting from image bit `frameLen-1` and ending at image bit 0. A receive request takes a captured image laid out the same way and returns the data word together with a parity verdict.

The frame length is programmable. It always counts the parity bit when parity is on, so the data is one bit shorter than the frame in that case. The bit order can be MSB-first or LSB-first. Parity is optional, and it can be even or odd. Each request is a single-cycle strobe that carries all of its settings. The result is registered and appears one clock later. The serial shifting and bit clocking sit outside this block.

Top module: `frame_formatter`

## Requirements
- R1: The 6-bit `lenCode` gives the frame length L in plain binary. Codes below 8 act as 8, codes above 32 act as 32, and codes from 8 to 32 are used as given.
- R2: With `parEn`=0 the data length D equals L. On a transmit in MSB-first order (`msbFirst`=1), image bits [L-1:0] equal `dataIn[L-1:0]`. Image bits at position L and above are 0, whatever the input bits above D were.
- R3: With `parEn`=1, D = L-1. In MSB-first order, data bit i goes to image bit i+1 and the parity bit goes to image bit 0.
- R4: In LSB-first order (`msbFirst`=0), data bit i goes to image bit L-1-i, so D0 is the first bit sent. When parity is on, it still occupies image bit 0.
- R5: On transmit, the parity bit makes the number of ones across the D data bits plus the parity bit even when `parOdd`=0 and odd when `parOdd`=1.
- R6: On receive (`rxMode`=1), the data is read back through the inverse of the R2–R4 mapping for the chosen order. It is returned right-aligned with bits D and above cleared. Image bits at position L and above are ignored.
- R7: On receive with `parEn`=1, `parErr` is 1 exactly when the ones in the D data bits plus image bit 0 break the R5 rule. `parErr` is 0 after any transmit and after any receive with `parEn`=0.
- R8: `outValid` pulses high in the cycle after `inValid`. `dataOut` and `parErr` update only on that edge and hold otherwise. After reset, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe, one cycle per frame |
| rxMode | input | 1 | 0 = format for transmit, 1 = extract received frame |
| lenCode | input | 6 | Frame length code, parity bit included |
| msbFirst | input | 1 | 1 = MSB first, 0 = LSB first |
| parEn | input | 1 | Parity bit present |
| parOdd | input | 1 | 0 = even parity, 1 = odd parity |
| dataIn | input | 32 | Buffer word (transmit) or frame image (receive) |
| outValid | output | 1 | Result valid pulse |
| dataOut | output | 32 | Frame image (transmit) or extracted data (receive) |
| parErr | output | 1 | Parity mismatch on the last received frame |

## Verification
Transmit is tried with single-bit, all-ones and mixed words, each in both bit orders. This separates a reversed mapping from a plain shift, and a parity bit placed at the top of the frame from one placed at the bottom. Inputs deliberately carry ones above the data length, to expose a missing mask. Receive images carry junk above the frame so that a wrong shift amount shows up. The same data is tried with even and with odd parity, and with a corrupted parity bit, so that an inverted sense or a dead error flag is caught. Codes 0, 3, 7, 8, 32, 40 and 63 exercise both clamp limits and the edges of the legal range.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  // Strobes handed from the control to the datapath
  typedef struct packed {
    logic loadTx;
    logic loadRx;
  } fmtStrobe_t;
endpackage

// File: rtl/fmt_ctrl.sv
module fmt_ctrl
  import fmt_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LEN_W   = 6,
  parameter int MIN_LEN = 8
) (
  input  logic             inValid,
  input  logic             rxMode,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             parEn,
  output fmtStrobe_t       strobe,
  output logic [LEN_W:0]   frameLen,
  output logic [LEN_W:0]   dataLen
);
  localparam int LEN1_W = LEN_W + 1;
  localparam logic [LEN1_W-1:0] MIN_L = LEN1_W'(MIN_LEN);
  localparam logic [LEN1_W-1:0] MAX_L = LEN1_W'(WORD_W);

  logic [LEN1_W-1:0] codeWide;
  assign codeWide = {1'b0, lenCode};

  always_comb begin
    if (codeWide < MIN_L)      frameLen = MIN_L;
    else if (codeWide > MAX_L) frameLen = MAX_L;
    else                       frameLen = codeWide;
    dataLen = frameLen - LEN1_W'(parEn);
  end

  assign strobe.loadTx = inValid & ~rxMode;
  assign strobe.loadRx = inValid &  rxMode;
endmodule

// File: rtl/fmt_datapath.sv
module fmt_datapath
  import fmt_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtStrobe_t        strobe,
  input  logic [LEN_W:0]    frameLen,
  input  logic [LEN_W:0]    dataLen,
  input  logic              msbFirst,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic [WORD_W-1:0] dataIn,
  output logic              outValid,
  output logic [WORD_W-1:0] dataOut,
  output logic              parErr
);
  localparam int LEN1_W = LEN_W + 1;
  localparam logic [LEN1_W-1:0] WORD_L = LEN1_W'(WORD_W);

  logic [WORD_W-1:0] keepMask, txData, revTx, revIn, parBit, txImg, rxRaw, rxData;
  logic [LEN1_W-1:0] shiftDn;
  logic              txPar, rxErr;

  for (genvar g = 0; g < WORD_W; g++) begin : g_rev
    assign revTx[g] = txData[WORD_W-1-g];
    assign revIn[g] = dataIn[WORD_W-1-g];
  end

  always_comb begin
    keepMask = (dataLen >= WORD_L) ? '1 : ((WORD_W'(1) << dataLen) - WORD_W'(1));
    shiftDn  = WORD_L - frameLen;
    // transmit side
    txData = dataIn & keepMask;
    txPar  = (^txData) ^ parOdd;
    parBit = parEn ? WORD_W'(txPar) : '0;
    if (msbFirst) txImg = (txData << parEn) | parBit;
    else          txImg = (revTx >> shiftDn) | parBit;
    // receive side
    if (msbFirst) rxRaw = dataIn >> parEn;
    else          rxRaw = revIn >> shiftDn;
    rxData = rxRaw & keepMask;
    rxErr  = parEn & ((^rxData) ^ parOdd ^ dataIn[0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      dataOut  <= '0;
      parErr   <= 1'b0;
    end else begin
      outValid <= strobe.loadTx | strobe.loadRx;
      if (strobe.loadTx) begin
        dataOut <= txImg;
        parErr  <= 1'b0;
      end else if (strobe.loadRx) begin
        dataOut <= rxData;
        parErr  <= rxErr;
      end
    end
  end
endmodule

// File: rtl/frame_formatter.sv
module frame_formatter
  import fmt_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LEN_W   = 6,
  parameter int MIN_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              rxMode,
  input  logic [LEN_W-1:0]  lenCode,
  input  logic              msbFirst,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic [WORD_W-1:0] dataIn,
  output logic              outValid,
  output logic [WORD_W-1:0] dataOut,
  output logic              parErr
);
  fmtStrobe_t     strobe;
  logic [LEN_W:0] frameLen, dataLen;

  fmt_ctrl #(.WORD_W(WORD_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_ctrl (
    .inValid(inValid), .rxMode(rxMode), .lenCode(lenCode), .parEn(parEn),
    .strobe(strobe), .frameLen(frameLen), .dataLen(dataLen)
  );

  fmt_datapath #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameLen(frameLen),
    .dataLen(dataLen), .msbFirst(msbFirst), .parEn(parEn), .parOdd(parOdd),
    .dataIn(dataIn), .outValid(outValid), .dataOut(dataOut), .parErr(parErr)
  );
endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              rxMode,
  input logic              parEn,
  input logic              parOdd,
  input logic              outValid,
  input logic [WORD_W-1:0] dataOut,
  input logic              parErr
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);                                             // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);                                           // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(dataOut) && $stable(parErr));                 // R8
  AST_TX_PARITY_SENSE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !rxMode && parEn) |=> ((^dataOut) == $past(parOdd)));  // R5
  AST_TX_NO_PERR: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !rxMode) |=> !parErr);                                 // R7
  AST_NOPAR_NO_PERR: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !parEn) |=> !parErr);                                  // R7
  AST_RX_ZERO_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rxMode && parEn) |=> !dataOut[WORD_W-1]);              // R6
endmodule

bind frame_formatter fmt_checker #(.WORD_W(WORD_W)) u_fmtChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .rxMode(rxMode),
  .parEn(parEn), .parOdd(parOdd), .outValid(outValid),
  .dataOut(dataOut), .parErr(parErr)
);

// File: tb/tb_frame_formatter.sv
module tb_frame_formatter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, rxMode = 1'b0, msbFirst = 1'b1, parEn = 1'b0, parOdd = 1'b0;
  logic [5:0]  lenCode = 6'd8;
  logic [31:0] dataIn = '0;
  logic        outValid, parErr;
  logic [31:0] dataOut;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  frame_formatter dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .rxMode(rxMode), .lenCode(lenCode),
    .msbFirst(msbFirst), .parEn(parEn), .parOdd(parOdd), .dataIn(dataIn),
    .outValid(outValid), .dataOut(dataOut), .parErr(parErr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int clampLen(int code);
    if (code < 8) return 8;
    if (code > 32) return 32;
    return code;
  endfunction

  // position in the image of data bit i
  function automatic int bitPos(bit msb, int L, int pe, int i);
    return msb ? i + pe : L - 1 - i;
  endfunction

  function automatic logic [31:0] txModel(int code, bit msb, bit pe, bit po, logic [31:0] d);
    int L = clampLen(code);
    int D = L - int'(pe);
    int ones = 0;
    logic [31:0] img = '0;
    for (int i = 0; i < D; i++) begin
      img[bitPos(msb, L, int'(pe), i)] = d[i];
      ones += int'(d[i]);
    end
    if (pe) img[0] = (ones % 2 == 1) ^ po;
    return img;
  endfunction

  function automatic logic [32:0] rxModel(int code, bit msb, bit pe, bit po, logic [31:0] img);
    int L = clampLen(code);
    int D = L - int'(pe);
    int ones = 0;
    logic [31:0] d = '0;
    logic err;
    for (int i = 0; i < D; i++) begin
      d[i] = img[bitPos(msb, L, int'(pe), i)];
      ones += int'(d[i]);
    end
    ones += int'(img[0]);
    err = pe && ((ones % 2 == 1) != po);
    return {err, d};
  endfunction

  // one request; result sampled at the negedge after the capturing posedge
  task automatic issue(bit rx, int code, bit msb, bit pe, bit po, logic [31:0] d);
    @(negedge clk);
    inValid = 1'b1; rxMode = rx; lenCode = 6'(code); msbFirst = msb;
    parEn = pe; parOdd = po; dataIn = d;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic run(string tag, bit rx, int code, bit msb, bit pe, bit po, logic [31:0] d);
    logic [32:0] r;
    issue(rx, code, msb, pe, po, d);
    chk({tag, " valid"}, 32'(outValid), 32'd1);
    if (rx) begin
      r = rxModel(code, msb, pe, po, d);
      chk({tag, " data"}, dataOut, r[31:0]);
      chk({tag, " perr"}, 32'(parErr), 32'(r[32]));
    end else begin
      chk({tag, " image"}, dataOut, txModel(code, msb, pe, po, d));
      chk({tag, " perr"}, 32'(parErr), 32'd0);
    end
  endtask

  task automatic t_reset;
    chk("R8 reset valid", 32'(outValid), 32'd0);
    chk("R8 reset data", dataOut, 32'd0);
    chk("R8 reset perr", 32'(parErr), 32'd0);
  endtask

  task automatic t_tx_nopar;
    issue(0, 16, 1, 0, 0, 32'hABCD_1234);
    chk("R2 msb16 literal", dataOut, 32'h0000_1234);
    run("R2 msb32", 0, 32, 1, 0, 0, 32'hDEAD_BEEF);
    run("R2 msb13 mask", 0, 13, 1, 0, 0, 32'hFFFF_A5A5);
  endtask

  task automatic t_tx_par_msb;
    issue(0, 16, 1, 1, 0, 32'hFFFF_7FFF);
    chk("R3 msb16 even literal", dataOut, 32'h0000_FFFF);
    run("R3 msb11", 0, 11, 1, 1, 0, 32'h0000_0155);
    run("R3 msb32", 0, 32, 1, 1, 0, 32'hF0F0_1234);
  endtask

  task automatic t_lsb;
    issue(0, 8, 0, 0, 0, 32'h0000_0001);
    chk("R4 lsb8 literal", dataOut, 32'h0000_0080);
    run("R4 lsb16 par", 0, 16, 0, 1, 0, 32'h0000_3A5C);
    run("R4 lsb32", 0, 32, 0, 0, 0, 32'h1234_5678);
    run("R4 lsb31 par", 0, 31, 0, 1, 1, 32'hC001_D00D);
  endtask

  task automatic t_sense;
    issue(0, 9, 1, 1, 1, 32'h0000_00FF);
    chk("R5 odd literal", dataOut, 32'h0000_01FF);
    issue(0, 9, 1, 1, 0, 32'h0000_00FF);
    chk("R5 even literal", dataOut, 32'h0000_01FE);
    run("R5 odd lsb", 0, 20, 0, 1, 1, 32'h0004_1111);
  endtask

  task automatic t_clamp;
    issue(0, 3, 1, 0, 0, 32'hFFFF_FFFF);
    chk("R1 code3 as 8", dataOut, 32'h0000_00FF);
    issue(0, 40, 1, 0, 0, 32'h8000_0001);
    chk("R1 code40 as 32", dataOut, 32'h8000_0001);
    run("R1 code0", 0, 0, 0, 0, 0, 32'h0000_0003);
    run("R1 code63", 0, 63, 0, 1, 0, 32'h7FFF_0001);
    run("R1 code7", 1, 7, 1, 1, 0, 32'hFFFF_FF01);
    run("R1 code8", 0, 8, 1, 1, 1, 32'h0000_007F);
  endtask

  task automatic t_rx;
    issue(1, 16, 1, 1, 0, 32'hABCD_FFFF);
    chk("R6 msb16 literal", dataOut, 32'h0000_7FFF);
    chk("R7 msb16 good perr", 32'(parErr), 32'd0);
    run("R6 lsb12", 1, 12, 0, 0, 0, 32'hFFFF_F123);
    run("R6 lsb24 par", 1, 24, 0, 1, 1, 32'hEE12_3457);
    run("R6 msb32", 1, 32, 1, 0, 0, 32'h89AB_CDEF);
    run("R6 round trip", 1, 18, 0, 1, 0, txModel(18, 0, 1, 0, 32'h0001_2345));
  endtask

  task automatic t_rx_err;
    issue(1, 16, 1, 1, 0, 32'h0000_FFFE);
    chk("R7 bad parity data", dataOut, 32'h0000_7FFF);
    chk("R7 bad parity flag", 32'(parErr), 32'd1);
    issue(1, 16, 1, 1, 1, 32'h0000_FFFE);
    chk("R7 odd good flag", 32'(parErr), 32'd0);
    run("R7 lsb err", 1, 10, 0, 1, 0, txModel(10, 0, 1, 0, 32'h155) ^ 32'h1);
    issue(1, 16, 1, 0, 0, 32'h0000_0001);
    chk("R7 nopar no flag", 32'(parErr), 32'd0);
  endtask

  task automatic t_hold;
    issue(1, 16, 1, 1, 0, 32'h0000_FFFE);
    @(negedge clk);
    rxMode = 1'b0; dataIn = 32'h5555_5555; lenCode = 6'd32; parEn = 1'b0;
    @(negedge clk);
    chk("R8 hold valid low", 32'(outValid), 32'd0);
    chk("R8 hold data", dataOut, 32'h0000_7FFF);
    chk("R8 hold perr", 32'(parErr), 32'd1);
  endtask

  initial begin
    #1;
    t_reset;
    #6 rstN = 1'b1;
    t_tx_nopar;
    t_tx_par_msb;
    t_lsb;
    t_sense;
    t_clamp;
    t_rx;
    t_rx_err;
    t_hold;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule